// File: doc/BRIEF.md
# Charge-Pump Gain Selection Controller

This controller decides whether an LED-driver charge pump runs at unity gain (1x) or at the boosted gain of 3/2x. Each current sink in the two main LED banks has an analog comparator that reports when the voltage across that sink has dropped below its regulation threshold. The controller only looks at the sinks that are actually driving. A sink belonging to a disabled bank is masked out. The fifth sink of bank A is watched only when its sense enable is set, and the third sink of bank B is watched only when that driver is enabled. The indicator sink has no comparator input and never affects the gain.

A flag must stay asserted on one monitored sink for a programmable number of consecutive clocks before the gain rises to 3/2x. This filters out comparator glitches. Leaving 3/2x is deliberately harder. Every monitored flag must have been clear for at least `hold_cycles` clocks, and the drop to 1x happens only on a clock where the enable configuration changes. Without that second condition the pump could toggle between the two gains whenever the headroom sits close to the threshold.

The pump is shut down when all three bank enables are low or when the thermal-shutdown flag is set. In shutdown, and in reset, the gain is forced to 1x, the pump enable is low, and all filter and hold history is cleared.

Top module: `pump_gain_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released with all enables low, `gain_hi` is 0 and `pump_en` is 0.
- R2: `pump_en` is a registered copy of (`en_a` OR `en_b` OR `en_c`) AND NOT `therm_sd`, valid one clock after the inputs are sampled.
- R3: When one monitored flag is high on FILT_LEN (default 8) consecutive rising edges, `gain_hi` becomes 1 at the edge that samples the last of them.
- R4: A run shorter than FILT_LEN clocks on a pin leaves `gain_hi` at 0. The run restarts from zero whenever that pin's flag, or its mask, is low.
- R5: Flags of a disabled bank are ignored. Bits `low_hr_a[i]` map to bank A sink i+1 and are masked by `en_a`. Bits `low_hr_b[i]` map to bank B sink i+1 and are masked by `en_b`.
- R6: `low_hr_a[4]` (bank A sink 5) counts only while `sense_d5a` is 1. `low_hr_b[2]` (bank B sink 3) counts only while `en_d3b` is 1.
- R7: The indicator enable `en_c` turns the pump on but makes no flag monitored. With only `en_c` set, `gain_hi` stays 0 whatever the flags.
- R8: From 3/2x, `gain_hi` returns to 0 at an edge where the enable vector {en_a, en_b, en_c, sense_d5a, en_d3b} differs from its value at the previous edge, no monitored flag is high, and the monitored flags have been clear on at least `hold_cycles` preceding edges.
- R9: Without an enable change, `gain_hi` stays at 1 however long the flags stay clear. A change that comes before the quiet interval is complete also leaves it at 1.
- R10: Shutdown (thermal flag set, or all of `en_a`, `en_b` and `en_c` low) clears `gain_hi` and `pump_en` at the next edge and discards filter progress. `gain_hi` is never 1 while `pump_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| low_hr_a | input | 5 | Bank A low-headroom flags, bit i = sink i+1 |
| low_hr_b | input | 3 | Bank B low-headroom flags, bit i = sink i+1 |
| en_a | input | 1 | Bank A enable |
| en_b | input | 1 | Bank B enable |
| en_c | input | 1 | Indicator sink enable |
| sense_d5a | input | 1 | Headroom sensing on bank A sink 5 |
| en_d3b | input | 1 | Bank B sink 3 driver and sensing enable |
| therm_sd | input | 1 | Thermal-shutdown flag |
| hold_cycles | input | 16 | Quiet interval required before leaving 3/2x |
| gain_hi | output | 1 | 1 = 3/2x gain, 0 = 1x |
| pump_en | output | 1 | Charge-pump enable |

## Verification
The gain decision is exercised with several flag patterns:
- Runs of seven and of eight clocks on one pin show where the persistence filter triggers.
- The same flags are raised with their bank disabled, or with the per-pin sense bit clear, to separate a masked pin from a monitored one.
- Flags are raised with only the indicator enabled, to show that this enable powers the pump but monitors nothing.

The release path is tested three ways:
- A long quiet interval with no enable change.
- An enable change that comes before the quiet interval is complete.
- An enable change that comes after it.

Together these show that both conditions are needed. A behavioural reference model runs beside the design, so every other cycle of these patterns is compared as well.

// File: rtl/pump_gain_ctrl.sv
module pump_gain_ctrl #(
  parameter int FILT_LEN = 8,
  parameter int HOLD_W   = 16,
  parameter int NA       = 5,
  parameter int NB       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NA-1:0]     low_hr_a,
  input  logic [NB-1:0]     low_hr_b,
  input  logic              en_a,
  input  logic              en_b,
  input  logic              en_c,
  input  logic              sense_d5a,
  input  logic              en_d3b,
  input  logic              therm_sd,
  input  logic [HOLD_W-1:0] hold_cycles,
  output logic              gain_hi,
  output logic              pump_en
);
  localparam int CW = $clog2(FILT_LEN);
  localparam int NP = NA + NB;
  localparam logic [CW-1:0] TRIP = CW'(FILT_LEN - 1);

  logic          shut;
  logic [NA-1:0] mask_a;
  logic [NB-1:0] mask_b;
  logic [NP-1:0] mon, trip;
  logic          any_mon, en_chg, quiet;
  logic [4:0]    en_vec, en_prev;
  logic [HOLD_W-1:0] clr_cnt;

  assign shut    = !(en_a || en_b || en_c) || therm_sd;
  assign mask_a  = {NA{en_a}} & {sense_d5a, {(NA-1){1'b1}}};
  assign mask_b  = {NB{en_b}} & {en_d3b, {(NB-1){1'b1}}};
  assign mon     = {low_hr_b & mask_b, low_hr_a & mask_a};
  assign any_mon = |mon;
  assign en_vec  = {en_a, en_b, en_c, sense_d5a, en_d3b};
  assign en_chg  = en_vec != en_prev;
  assign quiet   = !any_mon && (clr_cnt >= hold_cycles);

  for (genvar i = 0; i < NP; i++) begin : g_filt
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n || shut || !mon[i]) cnt <= '0;
      else if (cnt != TRIP)          cnt <= cnt + 1'b1;
    end
    assign trip[i] = mon[i] && !shut && (cnt == TRIP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_cnt <= '0;
      en_prev <= '0;
      gain_hi <= 1'b0;
      pump_en <= 1'b0;
    end else begin
      en_prev <= en_vec;
      pump_en <= !shut;
      if (shut || any_mon)  clr_cnt <= '0;
      else if (~&clr_cnt)   clr_cnt <= clr_cnt + 1'b1;
      if (shut)                  gain_hi <= 1'b0;
      else if (|trip)            gain_hi <= 1'b1;
      else if (en_chg && quiet)  gain_hi <= 1'b0;
    end
  end
endmodule

// File: rtl/pump_gain_ctrl_chk.sv
module pump_gain_ctrl_chk #(
  parameter int FILT_LEN = 8,
  parameter int NA       = 5,
  parameter int NB       = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NA-1:0] low_hr_a,
  input logic [NB-1:0] low_hr_b,
  input logic          en_a,
  input logic          en_b,
  input logic          en_c,
  input logic          sense_d5a,
  input logic          en_d3b,
  input logic          therm_sd,
  input logic          gain_hi,
  input logic          pump_en
);
  localparam int RW = $clog2(FILT_LEN + 1) + 1;
  logic [RW-1:0] run;
  logic          off, flagged;
  logic [4:0]    en_vec;

  assign off     = therm_sd || !(en_a || en_b || en_c);
  assign flagged = !off && ((en_a && |(low_hr_a & {sense_d5a, {(NA-1){1'b1}}})) ||
                            (en_b && |(low_hr_b & {en_d3b, {(NB-1){1'b1}}})));
  assign en_vec  = {en_a, en_b, en_c, sense_d5a, en_d3b};

  always_ff @(posedge clk) begin
    if (!rst_n || !flagged) run <= '0;
    else if (run < RW'(FILT_LEN)) run <= run + 1'b1;
  end

  // R10
  shutdown_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> (!gain_hi && !pump_en));
  // R10
  gain_needs_pump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gain_hi |-> pump_en);
  // R2
  pump_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pump_en == !$past(off)));
  // R3
  rise_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gain_hi) |-> (run >= RW'(FILT_LEN)));
  // R8
  fall_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gain_hi) |-> ($past(off) || ($past(en_vec) != $past(en_vec, 2))));
endmodule

bind pump_gain_ctrl pump_gain_ctrl_chk #(.FILT_LEN(FILT_LEN), .NA(NA), .NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .low_hr_a(low_hr_a), .low_hr_b(low_hr_b),
  .en_a(en_a), .en_b(en_b), .en_c(en_c), .sense_d5a(sense_d5a), .en_d3b(en_d3b),
  .therm_sd(therm_sd), .gain_hi(gain_hi), .pump_en(pump_en));

// File: tb/pump_gain_ctrl_tb.sv
module pump_gain_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic [4:0] low_hr_a = '0;
  logic [2:0] low_hr_b = '0;
  logic en_a = 0, en_b = 0, en_c = 0, sense_d5a = 0, en_d3b = 0, therm_sd = 0;
  logic [15:0] hold_cycles = 16'd20;
  logic gain_hi, pump_en;

  pump_gain_ctrl u_dut (.clk(clk), .rst_n(rst_n), .low_hr_a(low_hr_a), .low_hr_b(low_hr_b),
    .en_a(en_a), .en_b(en_b), .en_c(en_c), .sense_d5a(sense_d5a), .en_d3b(en_d3b),
    .therm_sd(therm_sd), .hold_cycles(hold_cycles), .gain_hi(gain_hi), .pump_en(pump_en));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  string phase = "R1";
  bit done = 0;

  int cnt_p[8];
  int quiet_run = 0;
  bit m_gain = 0, m_pump = 0;
  logic [4:0] prev_env = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (cnt_p[i]) cnt_p[i] = 0;
      quiet_run = 0; m_gain = 0; m_pump = 0; prev_env = '0;
    end else begin
      bit shut, raise, anym, chg;
      bit watched[8];
      logic [4:0] env;
      shut = !(en_a || en_b || en_c) || therm_sd;
      for (int i = 0; i < 5; i++) watched[i] = en_a && low_hr_a[i] && (i != 4 || sense_d5a);
      for (int i = 0; i < 3; i++) watched[5+i] = en_b && low_hr_b[i] && (i != 2 || en_d3b);
      raise = 0; anym = 0;
      for (int i = 0; i < 8; i++) begin
        if (watched[i]) anym = 1;
        if (watched[i] && !shut) begin
          cnt_p[i]++;
          if (cnt_p[i] >= 8) raise = 1;
        end else cnt_p[i] = 0;
      end
      env = {en_a, en_b, en_c, sense_d5a, en_d3b};
      chg = env != prev_env;
      if (shut) m_gain = 0;
      else if (raise) m_gain = 1;
      else if (m_gain && chg && !anym && quiet_run >= int'(hold_cycles)) m_gain = 0;
      if (shut || anym) quiet_run = 0; else quiet_run++;
      prev_env = env;
      m_pump = !shut;
    end
  end

  always @(negedge clk) if (!done) begin
    checks++;
    if (gain_hi !== m_gain || pump_en !== m_pump) begin
      fails++;
      $display("FAIL %s model compare: gain_hi=%b pump_en=%b expected %b %b",
               phase, gain_hi, pump_en, m_gain, m_pump);
    end
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_out(bit g, bit p, string tag);
    checks++;
    if (gain_hi !== g || pump_en !== p) begin
      fails++;
      $display("FAIL %s: gain_hi=%b pump_en=%b expected %b %b", tag, gain_hi, pump_en, g, p);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    run(3);
    expect_out(0, 0, "R1 in reset");
    rst_n = 1;
    run(1);
    expect_out(0, 0, "R1 after release");

    phase = "R2";
    en_a = 1; sense_d5a = 1;
    run(1);
    expect_out(0, 1, "R2 pump on");
    run(3);

    phase = "R4";
    low_hr_a[0] = 1; run(7); low_hr_a[0] = 0; run(1);
    expect_out(0, 1, "R4 seven-cycle run");
    low_hr_a[1] = 1; run(4); low_hr_a[1] = 0; low_hr_a[2] = 1; run(4); low_hr_a[2] = 0; run(1);
    expect_out(0, 1, "R4 runs split across pins");

    phase = "R3";
    low_hr_a[3] = 1; run(7);
    expect_out(0, 1, "R3 before eighth edge");
    run(1);
    expect_out(1, 1, "R3 eighth edge");
    low_hr_a[3] = 0;

    phase = "R9";
    run(40);
    expect_out(1, 1, "R9 quiet without change");

    phase = "R8";
    en_c = 1; run(1);
    expect_out(0, 1, "R8 change after quiet");

    phase = "R9";
    low_hr_a[0] = 1; run(8); low_hr_a[0] = 0;
    expect_out(1, 1, "R9 re-raise");
    run(5); en_c = 0; run(1);
    expect_out(1, 1, "R9 early change ignored");
    run(25);

    phase = "R5";
    en_c = 1; run(1);
    expect_out(0, 1, "R5 drop before bank test");
    low_hr_b = 3'b111; run(12);
    expect_out(0, 1, "R5 disabled bank B");
    low_hr_b = '0;

    phase = "R6";
    sense_d5a = 0; run(1);
    low_hr_a[4] = 1; run(12);
    expect_out(0, 1, "R6 sink5 unsensed");
    low_hr_a[4] = 0;
    en_b = 1; en_d3b = 0; run(1);
    low_hr_b[2] = 1; run(12);
    expect_out(0, 1, "R6 sink3 disabled");
    en_d3b = 1; run(8);
    expect_out(1, 1, "R6 sink3 enabled");
    low_hr_b[2] = 0; run(25);
    en_d3b = 0; run(1);
    expect_out(0, 1, "R8 drop via d3b change");

    phase = "R7";
    en_a = 0; en_b = 0; en_c = 1; run(2);
    low_hr_a = 5'h1F; low_hr_b = 3'h7; run(15);
    expect_out(0, 1, "R7 indicator only");
    low_hr_a = '0; low_hr_b = '0;

    phase = "R10";
    en_a = 1; low_hr_a[1] = 1; run(8);
    expect_out(1, 1, "R10 raised before shutdown");
    therm_sd = 1; run(1);
    expect_out(0, 0, "R10 thermal shutdown");
    run(3); therm_sd = 0; run(7);
    expect_out(0, 1, "R10 filter restarted");
    run(1);
    expect_out(1, 1, "R10 re-raise after recovery");
    low_hr_a[1] = 0;
    en_a = 0; en_c = 0; run(1);
    expect_out(0, 0, "R10 all enables low");
    run(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule